// File: doc/BRIEF.md
# Multiplexed Two-Phase Address Latch

This block is the device-side front end of a memory whose 16-bit bus carries both address and data. The host sends a word address in two bus phases, each framed by a low pulse on an active-low address strobe. The first phase carries the upper half of the address. The host then pulls the read enable low for a while. The second phase carries the lower half. All host pins are oversampled by a fast system clock: a synchroniser chain and an edge detector find the strobe edges, and a small state machine decides which half each pulse belongs to.

A phase counts only if the chip is selected, not being written and not being read when the strobe falls. The two-phase scheme is active only while the asynchronous read mode input is high. When the lower half arrives, the block puts out the assembled address together with a one-cycle completion pulse. The low bits of that address also appear separately as the array index. A deselect or a mode change between the phases throws away the upper half.

Top module: `mux_addr_latch`

## Requirements
- R1: While reset is high and in the first cycle after it, `addr_valid` is 0 and `addr_out` is 0.
- R2: A first phase carrying U, then a low level on `oe_n`, then a second phase carrying L set `addr_out` = {U, L} (U in bits 31:16, L in bits 15:0). `addr_valid` is high for exactly one cycle, after the third rising clock edge that follows the second strobe's rise. A first phase on its own gives no pulse.
- R3: `arr_idx` equals bits 21:0 of `addr_out`.
- R4: A strobe pulse counts as a phase only if `ce_n`=0, `we_n`=1 and `oe_n`=1 when it falls. Any other pulse is ignored, and the pending sequence continues.
- R5: A strobe low for fewer than 2 system clocks is ignored. A low of 2 or more clocks is accepted.
- R6: If `ce_n` goes high after a first phase, the upper half is discarded. The next accepted phase is treated as a first phase.
- R7: A second qualified phase that comes before any low level on `oe_n` replaces the upper half and does not complete an address.
- R8: While `cfg_async` is 0, no phase is accepted and no pulse is produced. Dropping it between phases discards the upper half.
- R9: `addr_out` changes only in a cycle where `addr_valid` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample all host pins |
| rst | input | 1 | Synchronous reset, active high |
| cfg_async | input | 1 | Asynchronous read mode select; 1 enables two-phase capture |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output (read) enable, active low |
| strb_n | input | 1 | Address strobe, active low |
| ad_bus | input | 16 | Shared address/data bus |
| addr_out | output | 32 | Assembled address {upper, lower} |
| arr_idx | output | 22 | Low 22 bits of the address, used as the array index |
| addr_valid | output | 1 | One-cycle pulse when a full address has been captured |

## Verification
A stale upper half shows at the ports only when the next lower phase completes. It then appears as a wrong bits 31:16 field or as a pulse that should not be there. For that reason the bench follows every abort, ignored pulse and restart with a full completion and compares the whole 32-bit word. A wrong qualification or pulse-width decision shows as a missing or extra `addr_valid`. The bench sees this at the fixed three-edge latency after the strobe rises. A sweep over walking-one and arithmetic address patterns exposes swapped or misaligned halves on the first affected completion.

// File: rtl/mal_pkg.sv
package mal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_HAVE_UPPER = 2'd1,
    ST_OE_SEEN    = 2'd2
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic strb_n;
  } ctrl_t;
endpackage

// File: rtl/mal_sync.sv
module mal_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mal_strobe_det.sv
module mal_strobe_det #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strb_n_s,
  output logic fall,
  output logic rise_long,
  output logic rise_short
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic          prev_q;
  logic [CW-1:0] low_cnt_q;
  logic          rise;
  logic          long_enough;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= 1'b1;
      low_cnt_q <= '0;
    end else begin
      prev_q <= strb_n_s;
      if (strb_n_s)
        low_cnt_q <= '0;
      else if (low_cnt_q != CW'(MIN_LOW))
        low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  always_comb begin
    fall        = prev_q & ~strb_n_s;
    rise        = ~prev_q & strb_n_s;
    long_enough = (low_cnt_q >= CW'(MIN_LOW));
    rise_long   = rise & long_enough;
    rise_short  = rise & ~long_enough;
  end
endmodule

// File: rtl/mal_phase_ctrl.sv
module mal_phase_ctrl
  import mal_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_async,
  input  logic               ce_n_s,
  input  logic               we_n_s,
  input  logic               oe_n_s,
  input  logic [BUS_W-1:0]   bus_s,
  input  logic               fall,
  input  logic               rise_long,
  output logic [2*BUS_W-1:0] addr_q,
  output logic               valid_q,
  output phase_e             st_q,
  output logic               qual_q
);
  logic [BUS_W-1:0] upper_q;
  logic             abort;
  logic             take;

  assign abort = ce_n_s | ~cfg_async;
  assign take  = rise_long & qual_q;

  // qualification is decided at the strobe fall and held until the rise
  always_ff @(posedge clk) begin
    if (rst)             qual_q <= 1'b0;
    else if (abort)      qual_q <= 1'b0;
    else if (fall)       qual_q <= we_n_s & oe_n_s;
    else if (rise_long)  qual_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      upper_q <= '0;
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (abort) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (take) begin
              upper_q <= bus_s;
              st_q    <= ST_HAVE_UPPER;
            end
          end
          ST_HAVE_UPPER: begin
            if (take)         upper_q <= bus_s;
            else if (!oe_n_s) st_q    <= ST_OE_SEEN;
          end
          ST_OE_SEEN: begin
            if (take) begin
              addr_q  <= {upper_q, bus_s};
              valid_q <= 1'b1;
              st_q    <= ST_IDLE;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mux_addr_latch.sv
module mux_addr_latch
  import mal_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int ARRAY_W = 22,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_async,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic               strb_n,
  input  logic [BUS_W-1:0]   ad_bus,
  output logic [2*BUS_W-1:0] addr_out,
  output logic [ARRAY_W-1:0] arr_idx,
  output logic               addr_valid
);
  localparam int ADDR_W = 2 * BUS_W;
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_raw;
  logic [CTRL_W-1:0] ctrl_q;
  ctrl_t             ctrl_s;
  logic [BUS_W-1:0]  bus_s;
  logic              fall, rise_long, rise_short;
  phase_e            st;
  logic              qual;
  logic [ADDR_W-1:0] addr_q;

  assign ctrl_raw = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n, strb_n: strb_n};

  mal_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_ctrl_sync (
    .clk(clk), .rst(rst), .d(ctrl_raw), .q(ctrl_q)
  );
  assign ctrl_s = ctrl_t'(ctrl_q);

  // bus goes through the same depth so it lines up with the strobe edges
  mal_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst(rst), .d(ad_bus), .q(bus_s)
  );

  mal_strobe_det #(.MIN_LOW(MIN_LOW)) u_det (
    .clk(clk), .rst(rst), .strb_n_s(ctrl_s.strb_n),
    .fall(fall), .rise_long(rise_long), .rise_short(rise_short)
  );

  mal_phase_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_async(cfg_async),
    .ce_n_s(ctrl_s.ce_n), .we_n_s(ctrl_s.we_n), .oe_n_s(ctrl_s.oe_n),
    .bus_s(bus_s), .fall(fall), .rise_long(rise_long),
    .addr_q(addr_q), .valid_q(addr_valid), .st_q(st), .qual_q(qual)
  );

  assign addr_out = addr_q;
  assign arr_idx  = addr_q[ARRAY_W-1:0];
endmodule

// File: rtl/mal_checker.sv
module mal_checker
  import mal_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_async,
  input logic              addr_valid,
  input logic [ADDR_W-1:0] addr_out,
  input logic              ce_s,
  input phase_e            st,
  input logic              qual,
  input logic              rise_short
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> !addr_valid); // R2
  AST_COMPLETE_FROM_OE_SEEN: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> $past(st) == ST_OE_SEEN); // R7
  AST_QUALIFIED_PHASE: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> $past(qual)); // R4
  AST_SHORT_PULSE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    rise_short |=> !addr_valid); // R5
  AST_DESELECT_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && ce_s) |=> st == ST_IDLE); // R6
  AST_MODE_GATES_VALID: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> $past(cfg_async)); // R8
  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |-> $stable(addr_out)); // R9
endmodule

bind mux_addr_latch mal_checker #(.ADDR_W(ADDR_W)) u_mal_chk (
  .clk(clk), .rst(rst), .cfg_async(cfg_async), .addr_valid(addr_valid),
  .addr_out(addr_out), .ce_s(ctrl_s.ce_n), .st(st), .qual(qual),
  .rise_short(rise_short)
);

// File: tb/mux_addr_latch_test.sv
module mux_addr_latch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_async = 1'b1;
  logic        ce_n = 1'b0, we_n = 1'b1, oe_n = 1'b1, strb_n = 1'b1;
  logic [15:0] ad_bus = '0;
  logic [31:0] addr_out;
  logic [21:0] arr_idx;
  logic        addr_valid;

  int n_checks = 0;
  int n_err = 0;
  int pulse_cnt = 0;
  logic [31:0] last_exp = '0;

  always #4 clk = ~clk;

  mux_addr_latch uut (
    .clk(clk), .rst(rst), .cfg_async(cfg_async), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .strb_n(strb_n), .ad_bus(ad_bus), .addr_out(addr_out),
    .arr_idx(arr_idx), .addr_valid(addr_valid)
  );

  always @(negedge clk) if (addr_valid) pulse_cnt++;

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic phase(input logic [15:0] d, input int low_cyc, input logic we_v,
                       input logic oe_v, output logic v, output logic v_next);
    ad_bus = d; we_n = we_v; oe_n = oe_v;
    repeat (3) @(negedge clk);
    strb_n = 1'b0;
    repeat (low_cyc) @(negedge clk);
    strb_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 v = addr_valid;
    @(posedge clk);
    #1 v_next = addr_valid;
    @(negedge clk);
    ad_bus = d ^ 16'h5A3C; we_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic oe_gap();
    oe_n = 1'b0;
    repeat (3) @(negedge clk);
    oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic full_seq(input logic [31:0] exp, input int low_cyc);
    logic v1, n1, v2, n2;
    phase(exp[31:16], low_cyc, 1'b1, 1'b1, v1, n1);
    check(!v1 && !n1, "R2 first phase alone", {31'b0, v1 | n1}, 32'd0);
    oe_gap();
    phase(exp[15:0], low_cyc, 1'b1, 1'b1, v2, n2);
    check(v2, "R2 pulse at third edge", {31'b0, v2}, 32'd1);
    check(!n2, "R2 pulse one cycle", {31'b0, n2}, 32'd0);
    check(addr_out == exp, "R2 assembled address", addr_out, exp);
    check(arr_idx == exp[21:0], "R3 array index", {10'b0, arr_idx}, {10'b0, exp[21:0]});
    last_exp = exp;
  endtask

  initial begin
    logic v, vn;
    logic [31:0] x;
    int pc;
    repeat (4) @(negedge clk);
    check(addr_valid == 1'b0, "R1 valid in reset", {31'b0, addr_valid}, 32'd0);
    check(addr_out == 32'd0, "R1 addr in reset", addr_out, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(addr_valid == 1'b0 && addr_out == 32'd0, "R1 after reset", addr_out, 32'd0);
    repeat (3) @(negedge clk);

    // sweep: walking ones, then arithmetic patterns
    for (int i = 0; i < 32; i++) full_seq(32'd1 << i, 2 + (i % 3));
    x = 32'h1234_5678;
    for (int i = 0; i < 48; i++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      full_seq(x, 2 + (i % 2));
    end

    // R4: unqualified strobes between phases are ignored
    phase(16'hA1B2, 3, 1'b1, 1'b1, v, vn);
    oe_gap();
    phase(16'hFFFF, 3, 1'b0, 1'b1, v, vn);
    check(!v && !vn, "R4 write-enable low ignored", {31'b0, v}, 32'd0);
    phase(16'hEEEE, 3, 1'b1, 1'b0, v, vn);
    check(!v && !vn, "R4 output-enable low ignored", {31'b0, v}, 32'd0);
    phase(16'hC3D4, 3, 1'b1, 1'b1, v, vn);
    check(v && addr_out == 32'hA1B2_C3D4, "R4 sequence continues", addr_out, 32'hA1B2_C3D4);
    last_exp = 32'hA1B2_C3D4;

    // R5: one-clock strobe ignored, two-clock accepted
    phase(16'h0F0F, 2, 1'b1, 1'b1, v, vn);
    oe_gap();
    phase(16'h7777, 1, 1'b1, 1'b1, v, vn);
    check(!v && !vn, "R5 short pulse no valid", {31'b0, v}, 32'd0);
    phase(16'hF0F0, 2, 1'b1, 1'b1, v, vn);
    check(v && addr_out == 32'h0F0F_F0F0, "R5 short pulse left no trace", addr_out, 32'h0F0F_F0F0);
    last_exp = 32'h0F0F_F0F0;

    // R6: deselect between phases discards upper half
    phase(16'hDEAD, 3, 1'b1, 1'b1, v, vn);
    ce_n = 1'b1; repeat (4) @(negedge clk);
    ce_n = 1'b0; repeat (3) @(negedge clk);
    oe_gap();
    phase(16'h1357, 3, 1'b1, 1'b1, v, vn);
    check(!v && !vn, "R6 phase after abort is upper", {31'b0, v}, 32'd0);
    oe_gap();
    phase(16'h2468, 3, 1'b1, 1'b1, v, vn);
    check(v && addr_out == 32'h1357_2468, "R6 old upper discarded", addr_out, 32'h1357_2468);
    last_exp = 32'h1357_2468;

    // R7: no read-enable low between phases restarts the upper half
    phase(16'hAAAA, 3, 1'b1, 1'b1, v, vn);
    phase(16'hBBBB, 3, 1'b1, 1'b1, v, vn);
    check(!v && !vn, "R7 no oe gap no valid", {31'b0, v}, 32'd0);
    oe_gap();
    phase(16'hCCCC, 3, 1'b1, 1'b1, v, vn);
    check(v && addr_out == 32'hBBBB_CCCC, "R7 upper replaced", addr_out, 32'hBBBB_CCCC);
    last_exp = 32'hBBBB_CCCC;

    // R8: mode low blocks capture; dropping it mid-sequence discards
    cfg_async = 1'b0;
    pc = pulse_cnt;
    phase(16'h1111, 3, 1'b1, 1'b1, v, vn);
    oe_gap();
    phase(16'h2222, 3, 1'b1, 1'b1, v, vn);
    check(pulse_cnt == pc, "R8 no pulse in other mode", pulse_cnt, pc);
    check(addr_out == last_exp, "R8 address untouched", addr_out, last_exp);
    cfg_async = 1'b1;
    repeat (2) @(negedge clk);
    phase(16'h4444, 3, 1'b1, 1'b1, v, vn);
    cfg_async = 1'b0; repeat (3) @(negedge clk);
    cfg_async = 1'b1; repeat (2) @(negedge clk);
    oe_gap();
    phase(16'h5555, 3, 1'b1, 1'b1, v, vn);
    check(!v && !vn, "R8 mode drop discards upper", {31'b0, v}, 32'd0);
    oe_gap();
    phase(16'h6666, 3, 1'b1, 1'b1, v, vn);
    check(v && addr_out == 32'h5555_6666, "R8 fresh sequence", addr_out, 32'h5555_6666);
    last_exp = 32'h5555_6666;

    // R9: address holds while idle and during bus traffic
    pc = pulse_cnt;
    for (int i = 0; i < 20; i++) begin
      ad_bus = 16'(i * 16'h1111);
      @(negedge clk);
    end
    check(addr_out == last_exp, "R9 address holds", addr_out, last_exp);
    check(pulse_cnt == pc, "R9 no spurious pulse", pulse_cnt, pc);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule